// File: doc/BRIEF.md
# Exception Entry and Vectoring Unit

This unit sits beside a 32-bit RISC pipeline and handles the moment an exception is taken. The pipeline presents one exception per cycle as a valid strobe plus a kind code. With it come the faulting PC, a flag that marks an instruction sitting in a branch delay slot, a TLB-refill indication, a coprocessor number, and the current debug-mode state, which the unit holds itself. On the next clock edge the unit does two things. It updates the control state: the status bits, the cause fields, the three return-address registers and the sticky debug cause bits. It also presents a one-cycle redirect strobe with the handler address.

Exceptions fall into three classes:
- General exceptions save their return address only when the exception-level bit is clear.
- Error-level entries (non-maskable interrupt and soft reset) save into a separate error return register.
- Debug entries save into a debug return register and switch debug mode on.

The handler address depends on the class, the boot-vector bit, the interrupt-vector bit, the exception-level bit and the refill flag. A configuration write port loads the exception base, the boot-vector bit and the interrupt-vector bit.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset: exl_o=0, erl_o=1, bev_o=1, iv_o=0, bd_o=0, kern_o=0, debug_mode_o=0, nmi_flag_o=0, sr_flag_o=0, exc_code_o=0, ce_o=0, dbg_cause_o=0, ebase_o=0, and redirect_valid_o=0.
- R2: A defined kind with exc_valid_i=1 raises redirect_valid_o at the next edge, for exactly one cycle. Kinds 28, 29 and 31 are undefined: they produce no redirect and change no state.
- R3: The general kinds and their 5-bit codes are: interrupt 0, TLB modify 1, TLB load 2, TLB store 3, address error load 4, address error store 5, instruction bus error 6, data bus error 7, syscall 8, break 9, reserved instruction 10, coprocessor unusable 11, overflow 12, trap 13, floating point 15, coprocessor-2 precise 18, media extension 22, watch 23, machine check 24, thread 25, cache error 30. Each general kind's value equals its code, and that code is written to exc_code_o on entry.
- R4: A general handler address is base + offset, with offset 0x180 by default. The base is 0xBFC00200 when bev_o=1. When bev_o=0 the base is ebase_o with bits 9:0 cleared.
- R5: An interrupt (kind 0) uses offset 0x200 when iv_o=1.
- R6: An interrupt taken while debug_mode_o=1 is handled as a debug interrupt. It sets dbg_cause_o bit 1, redirects to 0xBFC00480 and leaves exl_o unchanged.
- R7: TLB load (2) or TLB store (3) with exc_refill_i=1 uses offset 0x000 only while exl_o=0. Otherwise it uses 0x180.
- R8: A cache error (30) uses offset 0x100 when bev_o=1 and offset 0x20000100 when bev_o=0.
- R9: A general entry with exl_o=0 does four things. It loads epc_o with the PC, or with PC-4 when exc_slot_i=1. It sets bd_o to exc_slot_i, sets exl_o and sets kern_o. When exl_o=1, epc_o and bd_o keep their values.
- R10: Coprocessor unusable (11) writes exc_cop_i into ce_o.
- R11: Non-maskable interrupt (kind 14) sets nmi_flag_o, and soft reset (kind 16) sets sr_flag_o. Both load error_epc_o using the PC-4 delay-slot rule, set erl_o, bev_o and kern_o, and redirect to 0xBFC00000. They clear bd_o only when exl_o=0.
- R12: The debug kinds each set one dbg_cause_o bit: single step (17) bit 0, debug interrupt (19) bit 1, instruction breakpoint (20) bit 2, breakpoint instruction (21) bit 3, data break store (26) bit 4, data break load (27) bit 5. Bits accumulate. A debug entry loads depc_o using the PC-4 delay-slot rule, sets debug_mode_o and kern_o, and redirects to 0xBFC00480.
- R13: Single step loads depc_o with the PC, whatever exc_slot_i is.
- R14: With cfg_we_i=1, ebase_o, bev_o and iv_o take cfg_ebase_i, cfg_bev_i and cfg_iv_i at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_valid_i | input | 1 | Exception presented this cycle |
| exc_kind_i | input | 5 | Exception kind code |
| exc_pc_i | input | 32 | Faulting PC |
| exc_slot_i | input | 1 | Instruction is in a branch delay slot |
| exc_refill_i | input | 1 | TLB miss is a refill |
| exc_cop_i | input | 2 | Coprocessor number for coprocessor unusable |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ebase_i | input | 32 | Exception base value to load |
| cfg_bev_i | input | 1 | Boot-vector bit to load |
| cfg_iv_i | input | 1 | Interrupt-vector bit to load |
| redirect_valid_o | output | 1 | One-cycle redirect strobe |
| redirect_pc_o | output | 32 | Handler address |
| epc_o | output | 32 | General return address |
| error_epc_o | output | 32 | Error-level return address |
| depc_o | output | 32 | Debug return address |
| ebase_o | output | 32 | Exception base register |
| exl_o | output | 1 | Exception level |
| erl_o | output | 1 | Error level |
| bev_o | output | 1 | Boot vectors selected |
| iv_o | output | 1 | Dedicated interrupt vector |
| bd_o | output | 1 | Last recorded exception was in a delay slot |
| kern_o | output | 1 | Kernel mode forced by an entry |
| nmi_flag_o | output | 1 | Non-maskable interrupt seen |
| sr_flag_o | output | 1 | Soft reset seen |
| debug_mode_o | output | 1 | Debug mode |
| exc_code_o | output | 5 | Cause exception code |
| ce_o | output | 2 | Cause coprocessor-error field |
| dbg_cause_o | output | 6 | Sticky debug cause bits |

## Verification
Every result of an entry is registered once. The redirect strobe, the handler address and every register update therefore appear at the first rising edge after the cycle in which exc_valid_i was high. The strobe falls again at the edge after that. The bench drives each stimulus on a falling edge and withdraws it on the next falling edge. At that moment exactly one rising edge has passed, so it samples all outputs of the entry there. It then waits one more edge to confirm that the strobe has dropped. State that must hold across later entries, such as a frozen EPC or accumulating debug bits, is read back after each subsequent entry at the same half-cycle offset.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int KIND_W = 5;
  localparam int CODE_W = 5;
  localparam int DBG_W  = 6;

  typedef enum logic [KIND_W-1:0] {
    K_INT      = 5'd0,  K_TLB_MOD  = 5'd1,  K_TLB_LD   = 5'd2,  K_TLB_ST  = 5'd3,
    K_ADR_LD   = 5'd4,  K_ADR_ST   = 5'd5,  K_IBUS     = 5'd6,  K_DBUS    = 5'd7,
    K_SYSCALL  = 5'd8,  K_BREAK    = 5'd9,  K_RSVD     = 5'd10, K_COP_UNU = 5'd11,
    K_OVF      = 5'd12, K_TRAP     = 5'd13, K_NMI      = 5'd14, K_FPE     = 5'd15,
    K_SRESET   = 5'd16, K_DSS      = 5'd17, K_COP2     = 5'd18, K_DINT    = 5'd19,
    K_DIB      = 5'd20, K_DBP      = 5'd21, K_MEDIA    = 5'd22, K_WATCH   = 5'd23,
    K_MCHECK   = 5'd24, K_THREAD   = 5'd25, K_DDBS     = 5'd26, K_DDBL    = 5'd27,
    K_CACHE    = 5'd30
  } exc_kind_e;

  typedef enum logic [1:0] {CLS_NONE, CLS_GEN, CLS_ERR, CLS_DBG} exc_class_e;

  localparam int DB_SS   = 0;
  localparam int DB_INT  = 1;
  localparam int DB_IBRK = 2;
  localparam int DB_BRKI = 3;
  localparam int DB_DST  = 4;
  localparam int DB_DLD  = 5;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_pkg::*;
(
  input  logic [KIND_W-1:0] kind_i,
  input  logic              dm_i,
  output exc_class_e        cls_o,
  output logic [CODE_W-1:0] code_o,
  output logic [DBG_W-1:0]  dbg_bit_o,
  output logic              is_int_o,
  output logic              is_tlb_miss_o,
  output logic              is_cache_o,
  output logic              is_cpu_o,
  output logic              is_nmi_o,
  output logic              is_dss_o
);
  logic [KIND_W-1:0] eff;

  // interrupt in debug mode becomes a debug interrupt
  assign eff = (kind_i == K_INT && dm_i) ? K_DINT : kind_i;

  always_comb begin
    cls_o     = CLS_GEN;
    code_o    = eff;
    dbg_bit_o = '0;
    unique case (eff)
      K_NMI, K_SRESET: cls_o = CLS_ERR;
      K_DSS:  begin cls_o = CLS_DBG; dbg_bit_o[DB_SS]   = 1'b1; end
      K_DINT: begin cls_o = CLS_DBG; dbg_bit_o[DB_INT]  = 1'b1; end
      K_DIB:  begin cls_o = CLS_DBG; dbg_bit_o[DB_IBRK] = 1'b1; end
      K_DBP:  begin cls_o = CLS_DBG; dbg_bit_o[DB_BRKI] = 1'b1; end
      K_DDBS: begin cls_o = CLS_DBG; dbg_bit_o[DB_DST]  = 1'b1; end
      K_DDBL: begin cls_o = CLS_DBG; dbg_bit_o[DB_DLD]  = 1'b1; end
      5'd28, 5'd29, 5'd31: cls_o = CLS_NONE;
      default: ;
    endcase
  end

  assign is_int_o      = (eff == K_INT);
  assign is_tlb_miss_o = (eff == K_TLB_LD) || (eff == K_TLB_ST);
  assign is_cache_o    = (eff == K_CACHE);
  assign is_cpu_o      = (eff == K_COP_UNU);
  assign is_nmi_o      = (eff == K_NMI);
  assign is_dss_o      = (eff == K_DSS);
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              BASE_LSB  = 10,
  parameter logic [XLEN-1:0] BOOT_GEN  = 32'hBFC0_0200,
  parameter logic [XLEN-1:0] ERR_VEC   = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] DBG_VEC   = 32'hBFC0_0480,
  parameter logic [XLEN-1:0] OFS_GEN   = 32'h0000_0180,
  parameter logic [XLEN-1:0] OFS_INT   = 32'h0000_0200,
  parameter logic [XLEN-1:0] OFS_REF   = 32'h0000_0000,
  parameter logic [XLEN-1:0] OFS_CBOOT = 32'h0000_0100,
  parameter logic [XLEN-1:0] OFS_CRUN  = 32'h2000_0100
) (
  input  exc_class_e      cls_i,
  input  logic            is_int_i,
  input  logic            is_tlb_miss_i,
  input  logic            is_cache_i,
  input  logic            refill_i,
  input  logic            exl_i,
  input  logic            bev_i,
  input  logic            iv_i,
  input  logic [XLEN-1:0] ebase_i,
  output logic [XLEN-1:0] pc_o
);
  localparam logic [XLEN-1:0] LOW_MASK = (XLEN'(1) << BASE_LSB) - XLEN'(1);

  logic [XLEN-1:0] base, ofs;

  assign base = bev_i ? BOOT_GEN : (ebase_i & ~LOW_MASK);

  always_comb begin
    ofs = OFS_GEN;
    if (is_cache_i)                           ofs = bev_i ? OFS_CBOOT : OFS_CRUN;
    else if (is_int_i && iv_i)                ofs = OFS_INT;
    else if (is_tlb_miss_i && refill_i && !exl_i) ofs = OFS_REF;
  end

  always_comb begin
    unique case (cls_i)
      CLS_ERR: pc_o = ERR_VEC;
      CLS_DBG: pc_o = DBG_VEC;
      default: pc_o = base + ofs;
    endcase
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter int              INSN_B  = 4,
  parameter logic [XLEN-1:0] ERR_VEC = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] DBG_VEC = 32'hBFC0_0480
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_valid_i,
  input  logic [KIND_W-1:0] exc_kind_i,
  input  logic [XLEN-1:0]   exc_pc_i,
  input  logic              exc_slot_i,
  input  logic              exc_refill_i,
  input  logic [1:0]        exc_cop_i,
  input  logic              cfg_we_i,
  input  logic [XLEN-1:0]   cfg_ebase_i,
  input  logic              cfg_bev_i,
  input  logic              cfg_iv_i,
  output logic              redirect_valid_o,
  output logic [XLEN-1:0]   redirect_pc_o,
  output logic [XLEN-1:0]   epc_o,
  output logic [XLEN-1:0]   error_epc_o,
  output logic [XLEN-1:0]   depc_o,
  output logic [XLEN-1:0]   ebase_o,
  output logic              exl_o,
  output logic              erl_o,
  output logic              bev_o,
  output logic              iv_o,
  output logic              bd_o,
  output logic              kern_o,
  output logic              nmi_flag_o,
  output logic              sr_flag_o,
  output logic              debug_mode_o,
  output logic [CODE_W-1:0] exc_code_o,
  output logic [1:0]        ce_o,
  output logic [DBG_W-1:0]  dbg_cause_o
);
  localparam logic [XLEN-1:0] SLOT_BACK = XLEN'(INSN_B);

  exc_class_e        cls;
  logic [CODE_W-1:0] code;
  logic [DBG_W-1:0]  dbg_bit;
  logic              is_int, is_tlb_miss, is_cache, is_cpu, is_nmi, is_dss;
  logic [XLEN-1:0]   vec_pc, ret_pc;

  logic              redir_q, exl_q, erl_q, bev_q, iv_q, bd_q, kern_q, nmi_q, sr_q, dm_q;
  logic [XLEN-1:0]   redir_pc_q, epc_q, erpc_q, depc_q, ebase_q;
  logic [CODE_W-1:0] code_q;
  logic [1:0]        ce_q;
  logic [DBG_W-1:0]  dbg_q;

  exc_classify i_classify (
    .kind_i(exc_kind_i), .dm_i(dm_q), .cls_o(cls), .code_o(code), .dbg_bit_o(dbg_bit),
    .is_int_o(is_int), .is_tlb_miss_o(is_tlb_miss), .is_cache_o(is_cache),
    .is_cpu_o(is_cpu), .is_nmi_o(is_nmi), .is_dss_o(is_dss)
  );

  exc_vector #(.XLEN(XLEN), .ERR_VEC(ERR_VEC), .DBG_VEC(DBG_VEC)) i_vector (
    .cls_i(cls), .is_int_i(is_int), .is_tlb_miss_i(is_tlb_miss), .is_cache_i(is_cache),
    .refill_i(exc_refill_i), .exl_i(exl_q), .bev_i(bev_q), .iv_i(iv_q),
    .ebase_i(ebase_q), .pc_o(vec_pc)
  );

  assign ret_pc = exc_slot_i ? exc_pc_i - SLOT_BACK : exc_pc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redir_q <= 1'b0; redir_pc_q <= '0;
      epc_q <= '0; erpc_q <= '0; depc_q <= '0; ebase_q <= '0;
      exl_q <= 1'b0; erl_q <= 1'b1; bev_q <= 1'b1; iv_q <= 1'b0; bd_q <= 1'b0;
      kern_q <= 1'b0; nmi_q <= 1'b0; sr_q <= 1'b0; dm_q <= 1'b0;
      code_q <= '0; ce_q <= '0; dbg_q <= '0;
    end else begin
      redir_q <= 1'b0;
      if (cfg_we_i) begin
        ebase_q <= cfg_ebase_i;
        bev_q   <= cfg_bev_i;
        iv_q    <= cfg_iv_i;
      end
      if (exc_valid_i) begin
        unique case (cls)
          CLS_GEN: begin
            if (!exl_q) begin
              epc_q  <= ret_pc;
              bd_q   <= exc_slot_i;
              exl_q  <= 1'b1;
              kern_q <= 1'b1;
            end
            code_q <= code;
            if (is_cpu) ce_q <= exc_cop_i;
          end
          CLS_ERR: begin
            if (is_nmi) nmi_q <= 1'b1;
            else        sr_q  <= 1'b1;
            erpc_q <= ret_pc;
            erl_q  <= 1'b1;
            bev_q  <= 1'b1;
            kern_q <= 1'b1;
            if (!exl_q) bd_q <= 1'b0;
          end
          CLS_DBG: begin
            dbg_q  <= dbg_q | dbg_bit;
            depc_q <= is_dss ? exc_pc_i : ret_pc;
            dm_q   <= 1'b1;
            kern_q <= 1'b1;
            if (!exl_q) bd_q <= 1'b0;
          end
          default: ;
        endcase
        if (cls != CLS_NONE) begin
          redir_q    <= 1'b1;
          redir_pc_q <= vec_pc;
        end
      end
    end
  end

  assign redirect_valid_o = redir_q;
  assign redirect_pc_o    = redir_pc_q;
  assign epc_o            = epc_q;
  assign error_epc_o      = erpc_q;
  assign depc_o           = depc_q;
  assign ebase_o          = ebase_q;
  assign exl_o            = exl_q;
  assign erl_o            = erl_q;
  assign bev_o            = bev_q;
  assign iv_o             = iv_q;
  assign bd_o             = bd_q;
  assign kern_o           = kern_q;
  assign nmi_flag_o       = nmi_q;
  assign sr_flag_o        = sr_q;
  assign debug_mode_o     = dm_q;
  assign exc_code_o       = code_q;
  assign ce_o             = ce_q;
  assign dbg_cause_o      = dbg_q;

  AST_REDIRECT_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i && cls != CLS_NONE |=> redirect_valid_o) else $error("redirect late"); // R2
  AST_NO_SPURIOUS_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_valid_i |=> !redirect_valid_o) else $error("spurious redirect"); // R2
  AST_EPC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exl_o |=> exl_o && $stable(epc_o)) else $error("epc moved at exl"); // R9
  AST_ERR_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i && cls == CLS_ERR |=> erl_o && bev_o && kern_o && redirect_pc_o == ERR_VEC)
    else $error("error entry"); // R11
  AST_DBG_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i && cls == CLS_DBG |=> debug_mode_o && redirect_pc_o == DBG_VEC)
    else $error("debug entry"); // R12
  AST_DBG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debug_mode_o |=> debug_mode_o && ((dbg_cause_o & $past(dbg_cause_o)) == $past(dbg_cause_o)))
    else $error("debug bits lost"); // R12
endmodule

// File: tb/test_exc_entry_unit.sv
`timescale 1ns/1ps
module test_exc_entry_unit;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        vld = 1'b0, slot = 1'b0, refill = 1'b0, cfg_we = 1'b0, cfg_bev = 1'b0, cfg_iv = 1'b0;
  logic [4:0]  kind = '0;
  logic [31:0] pc = '0, cfg_ebase = '0;
  logic [1:0]  cop = '0;
  logic        rv, exl, erl, bev, iv, bd, kern, nmi, sr, dm;
  logic [31:0] rpc, epc, erpc, depc, ebase;
  logic [4:0]  code;
  logic [1:0]  ce;
  logic [5:0]  dbg;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  exc_entry_unit i_exc_entry_unit (
    .clk_i(clk), .rst_ni(rst_n), .exc_valid_i(vld), .exc_kind_i(kind), .exc_pc_i(pc),
    .exc_slot_i(slot), .exc_refill_i(refill), .exc_cop_i(cop), .cfg_we_i(cfg_we),
    .cfg_ebase_i(cfg_ebase), .cfg_bev_i(cfg_bev), .cfg_iv_i(cfg_iv),
    .redirect_valid_o(rv), .redirect_pc_o(rpc), .epc_o(epc), .error_epc_o(erpc),
    .depc_o(depc), .ebase_o(ebase), .exl_o(exl), .erl_o(erl), .bev_o(bev), .iv_o(iv),
    .bd_o(bd), .kern_o(kern), .nmi_flag_o(nmi), .sr_flag_o(sr), .debug_mode_o(dm),
    .exc_code_o(code), .ce_o(ce), .dbg_cause_o(dbg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; vld = 1'b0; cfg_we = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic cfg(input logic [31:0] eb, input logic b, input logic v);
    @(negedge clk); cfg_we = 1'b1; cfg_ebase = eb; cfg_bev = b; cfg_iv = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // drive one exception; return half a cycle after the capturing edge
  task automatic raise(input logic [4:0] k, input logic [31:0] p, input logic s,
                       input logic rf, input logic [1:0] c);
    @(negedge clk); vld = 1'b1; kind = k; pc = p; slot = s; refill = rf; cop = c;
    @(negedge clk); vld = 1'b0; slot = 1'b0; refill = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 exl", exl, 0); chk("R1 erl", erl, 1); chk("R1 bev", bev, 1);
    chk("R1 iv", iv, 0); chk("R1 bd", bd, 0); chk("R1 kern", kern, 0);
    chk("R1 dm", dm, 0); chk("R1 flags", {nmi, sr}, 0); chk("R1 code", code, 0);
    chk("R1 ce", ce, 0); chk("R1 dbg", dbg, 0); chk("R1 ebase", ebase, 0);
    chk("R1 rv", rv, 0);
  endtask

  task automatic t_codes();
    int codes[21] = '{0,1,2,3,4,5,6,7,8,9,10,11,12,13,15,18,22,23,24,25,30};
    do_reset();
    foreach (codes[i]) begin
      raise(5'(codes[i]), 32'h100, 1'b0, 1'b0, 2'd0);
      chk("R3 code", code, codes[i]);
      chk("R2 redirect", rv, 1);
      if (codes[i] == 30) chk("R8 cache bev1", rpc, 32'hBFC0_0300);
      else                chk("R4 boot vector", rpc, 32'hBFC0_0380);
    end
  endtask

  task automatic t_general();
    do_reset();
    cfg(32'h8000_1234, 1'b0, 1'b0);
    chk("R14 ebase", ebase, 32'h8000_1234); chk("R14 bev", bev, 0); chk("R14 iv", iv, 0);
    raise(5'd8, 32'h0000_1000, 1'b0, 1'b0, 2'd0);
    chk("R4 ebase vector", rpc, 32'h8000_1180);
    chk("R9 epc", epc, 32'h0000_1000); chk("R9 bd", bd, 0);
    chk("R9 exl", exl, 1); chk("R9 kern", kern, 1);
    @(negedge clk); chk("R2 one cycle", rv, 0);
  endtask

  task automatic t_slot();
    do_reset();
    raise(5'd12, 32'h0000_2004, 1'b1, 1'b0, 2'd0);
    chk("R9 slot epc", epc, 32'h0000_2000); chk("R9 slot bd", bd, 1);
    raise(5'd13, 32'h0000_3000, 1'b0, 1'b0, 2'd0);
    chk("R9 epc held", epc, 32'h0000_2000); chk("R9 bd held", bd, 1);
    chk("R3 code updated", code, 13);
  endtask

  task automatic t_int_iv();
    do_reset();
    cfg(32'h8000_1234, 1'b0, 1'b1);
    chk("R14 iv", iv, 1);
    raise(5'd0, 32'h40, 1'b0, 1'b0, 2'd0);
    chk("R5 iv vector", rpc, 32'h8000_1200);
  endtask

  task automatic t_refill();
    do_reset();
    raise(5'd2, 32'h50, 1'b0, 1'b1, 2'd0);
    chk("R7 refill exl0", rpc, 32'hBFC0_0200);
    raise(5'd3, 32'h60, 1'b0, 1'b1, 2'd0);
    chk("R7 refill exl1", rpc, 32'hBFC0_0380); chk("R7 code", code, 3);
  endtask

  task automatic t_cache();
    do_reset();
    cfg(32'h8000_0000, 1'b0, 1'b0);
    raise(5'd30, 32'h70, 1'b0, 1'b0, 2'd0);
    chk("R8 cache bev0", rpc, 32'hA000_0100);
  endtask

  task automatic t_cpu();
    do_reset();
    raise(5'd11, 32'h80, 1'b0, 1'b0, 2'd2);
    chk("R10 ce", ce, 2); chk("R10 code", code, 11);
  endtask

  task automatic t_err();
    do_reset();
    cfg(32'h0, 1'b0, 1'b0);
    raise(5'd14, 32'h0000_4004, 1'b1, 1'b0, 2'd0);
    chk("R11 nmi flag", nmi, 1); chk("R11 errorepc", erpc, 32'h0000_4000);
    chk("R11 erl", erl, 1); chk("R11 bev", bev, 1); chk("R11 kern", kern, 1);
    chk("R11 vector", rpc, 32'hBFC0_0000); chk("R11 bd", bd, 0); chk("R11 sr", sr, 0);
    do_reset();
    raise(5'd12, 32'h0000_2004, 1'b1, 1'b0, 2'd0);
    raise(5'd16, 32'h0000_5000, 1'b0, 1'b0, 2'd0);
    chk("R11 sr flag", sr, 1); chk("R11 sr errorepc", erpc, 32'h0000_5000);
    chk("R11 bd kept exl1", bd, 1);
  endtask

  task automatic t_debug();
    do_reset();
    raise(5'd20, 32'h0000_6004, 1'b1, 1'b0, 2'd0);
    chk("R12 depc slot", depc, 32'h0000_6000); chk("R12 bit2", dbg, 6'b000100);
    chk("R12 dm", dm, 1); chk("R12 vector", rpc, 32'hBFC0_0480); chk("R12 kern", kern, 1);
    raise(5'd21, 32'h0000_6100, 1'b0, 1'b0, 2'd0);
    chk("R12 accumulate", dbg, 6'b001100); chk("R12 depc", depc, 32'h0000_6100);
    raise(5'd0, 32'h0000_6200, 1'b0, 1'b0, 2'd0);
    chk("R6 dint bit", dbg, 6'b001110); chk("R6 vector", rpc, 32'hBFC0_0480);
    chk("R6 exl unchanged", exl, 0);
    raise(5'd26, 32'h0000_6300, 1'b0, 1'b0, 2'd0);
    raise(5'd27, 32'h0000_6400, 1'b0, 1'b0, 2'd0);
    chk("R12 data break bits", dbg, 6'b111110);
  endtask

  task automatic t_dss();
    do_reset();
    raise(5'd17, 32'h0000_7004, 1'b1, 1'b0, 2'd0);
    chk("R13 depc no slot", depc, 32'h0000_7004); chk("R13 bit0", dbg, 6'b000001);
  endtask

  task automatic t_undef();
    do_reset();
    raise(5'd29, 32'h90, 1'b0, 1'b0, 2'd0);
    chk("R2 undef no redirect", rv, 0); chk("R2 undef exl", exl, 0);
    raise(5'd31, 32'h90, 1'b1, 1'b0, 2'd0);
    chk("R2 undef31", {rv, exl, bd, dm, kern}, 0);
    raise(5'd28, 32'h90, 1'b0, 1'b0, 2'd0);
    chk("R2 undef28", {rv, exl, erl, dbg, code}, {1'b0, 1'b0, 1'b1, 6'd0, 5'd0});
  endtask

  initial begin
    t_reset(); t_codes(); t_general(); t_slot(); t_int_iv(); t_refill();
    t_cache(); t_cpu(); t_err(); t_debug(); t_dss(); t_undef();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule